// File: doc/BRIEF.md
# Parallel-Load Tapped Shift Register

This block converts a parallel byte into a serial bit stream. It holds eight storage stages in a chain. While the mode control is low, every rising clock edge moves the contents one stage further along the chain and takes a new bit from the serial input into the first stage. While the mode control is high, the whole chain is overwritten from the eight parallel inputs. Only the last three stages (six, seven and eight) are visible at the outputs. Stage eight is the serial output.

A compile-time parameter, `LOAD_ASYNC`, sets how the parallel load is timed. With 0, the load happens on the rising clock edge. With 1, the load happens as soon as the mode control rises, with no clock edge needed. The ports are the same in both variants.

The block has no reset. Its contents are unknown until the first parallel load. When neither a clock edge nor a load occurs, the stages keep their values for any length of time.

The design has one two-state mode (`MODE_SHIFT`, `MODE_LOAD`). The mode is taken straight from the mode control. There is one transition each way: `MODE_SHIFT` to `MODE_LOAD` when the control rises, and back when it falls.

Top module: `srl_tapped`

## Requirements
- R1: The chain has eight stages. Bit i-1 of `par_in` goes to stage i. Stage eight is the serial end. After a load followed by k shifts (k = 0..7), `tap_out[2]` equals `par_in[7-k]` of the loaded byte.
- R2: `tap_out[0]`, `tap_out[1]` and `tap_out[2]` show stages six, seven and eight. Right after a load, `tap_out` equals `par_in[7:5]`. Once a load has occurred, the taps are never unknown.
- R3: On a rising clock edge with `load_mode` low, every stage takes the value of the stage before it, and stage one takes `ser_in`.
- R4: A bit that enters stage one on a rising edge appears on `tap_out[0]` after the sixth edge, on `tap_out[1]` after the seventh, and on `tap_out[2]` after the eighth. The capture edge counts as the first. The bit does not appear on `tap_out[0]` earlier than that.
- R5: With `LOAD_ASYNC` = 0, `load_mode` high loads the parallel inputs on the rising clock edge. Raising `load_mode` between edges leaves the outputs unchanged until the next edge.
- R6: With `LOAD_ASYNC` = 1:
  - A rise of `load_mode` loads the parallel inputs at once, with no clock edge.
  - The load repeats on every edge while the control stays high. `par_in` must be kept stable while `load_mode` is high between edges.
  - After `load_mode` falls, the outputs do not move until the next rising edge, and that edge performs the first shift.
- R7: With no rising clock edge and `load_mode` low, the outputs hold their values, whatever `ser_in` does.
- R8: While `load_mode` is high, `ser_in` has no effect on the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and clocked-load clock, rising edge |
| ser_in | input | 1 | Serial bit entering stage one |
| load_mode | input | 1 | 1 = parallel load, 0 = shift |
| par_in | input | 8 | Parallel data; bit i-1 feeds stage i |
| tap_out | output | 3 | Stages six (bit 0), seven (bit 1) and eight (bit 2) |

## Verification
Once the first load has happened, the checker tests on every clock edge:
- the one-stage advance of the taps during shifting;
- the six-edge latency from the serial input to the first tap, using a shadow history of serial bits;
- the load value for the selected variant;
- the absence of unknown values at the taps.

Some behaviour happens between clock edges and can only be shown by the bench's scenarios. These are:
- the level-sensitive load taking effect before any edge;
- the clocked load not taking effect early;
- the outputs holding while the clock is stopped and the serial input toggles.

The bench drives both variants side by side, and it also covers the byte ordering on the serial end.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } srl_mode_e;

endpackage

// File: rtl/srl_mode_decode.sv
module srl_mode_decode
    import srl_pkg::*;
(
    input  logic      load_mode,
    output srl_mode_e mode
);
    always_comb begin
        mode = load_mode ? MODE_LOAD : MODE_SHIFT;
    end
endmodule

// File: rtl/srl_next_state.sv
module srl_next_state
    import srl_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  srl_mode_e         mode,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    input  logic [STAGES-1:0] cur,
    output logic [STAGES-1:0] nxt
);
    always_comb begin
        unique case (mode)
            // stage i+1 (index i) takes stage i (index i-1); stage 1 takes the serial bit
            MODE_SHIFT: nxt = {cur[STAGES-2:0], ser_in};
            MODE_LOAD:  nxt = par_in;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/srl_store_clk.sv
module srl_store_clk #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic [STAGES-1:0] nxt,
    output logic [STAGES-1:0] q
);
    always_ff @(posedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/srl_store_lvl.sv
module srl_store_lvl #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              aload,
    input  logic [STAGES-1:0] par_in,
    input  logic [STAGES-1:0] nxt,
    output logic [STAGES-1:0] q
);
    always_ff @(posedge clk or posedge aload) begin
        if (aload) begin
            q <= par_in;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/srl_tapped.sv
module srl_tapped
    import srl_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int TAP_FIRST  = 6,
    parameter bit LOAD_ASYNC = 1'b0,
    localparam int TAP_W     = STAGES - TAP_FIRST + 1
) (
    input  logic              clk,
    input  logic              ser_in,
    input  logic              load_mode,
    input  logic [STAGES-1:0] par_in,
    output logic [TAP_W-1:0]  tap_out
);
    srl_mode_e         mode;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    srl_mode_decode u_mode (
        .load_mode (load_mode),
        .mode      (mode)
    );

    srl_next_state #(.STAGES(STAGES)) u_next (
        .mode   (mode),
        .ser_in (ser_in),
        .par_in (par_in),
        .cur    (stage_q),
        .nxt    (stage_d)
    );

    generate
        if (LOAD_ASYNC) begin : g_lvl
            srl_store_lvl #(.STAGES(STAGES)) u_store (
                .clk    (clk),
                .aload  (load_mode),
                .par_in (par_in),
                .nxt    (stage_d),
                .q      (stage_q)
            );
        end else begin : g_clk
            srl_store_clk #(.STAGES(STAGES)) u_store (
                .clk (clk),
                .nxt (stage_d),
                .q   (stage_q)
            );
        end
    endgenerate

    assign tap_out = stage_q[STAGES-1:TAP_FIRST-1];
endmodule

// File: rtl/srl_tapped_chk.sv
module srl_tapped_chk #(
    parameter int STAGES     = 8,
    parameter int TAP_FIRST  = 6,
    parameter bit LOAD_ASYNC = 1'b0,
    localparam int TAP_W     = STAGES - TAP_FIRST + 1,
    localparam int RUN_W     = $clog2(STAGES + 1)
) (
    input logic             clk,
    input logic             ser_in,
    input logic             load_mode,
    input logic [TAP_W-1:0] par_hi,
    input logic [TAP_W-1:0] tap_out
);
    logic              primed = 1'b0;
    logic [RUN_W-1:0]  shift_run = '0;
    logic [STAGES-1:0] ser_hist = '0;

    always_ff @(posedge clk) begin
        if (load_mode) begin
            primed    <= 1'b1;
            shift_run <= '0;
        end else begin
            ser_hist <= {ser_hist[STAGES-2:0], ser_in};
            if (shift_run < RUN_W'(STAGES)) shift_run <= shift_run + 1'b1;
        end
    end

    // R2: taps are defined once a load has happened
    a_r2_taps_known: assert property (@(posedge clk) disable iff (!primed)
        !$isunknown(tap_out));

    // R3: each shift moves the visible stages one step
    a_r3_shift_advance: assert property (@(posedge clk) disable iff (!primed)
        !load_mode |=> (load_mode || tap_out[TAP_W-1:1] == $past(tap_out[TAP_W-2:0])));

    // R4: a serial bit reaches the first tap after TAP_FIRST shifts
    a_r4_serial_latency: assert property (@(posedge clk) disable iff (!primed)
        (!load_mode && shift_run >= RUN_W'(TAP_FIRST)) |-> tap_out[0] == ser_hist[TAP_FIRST-1]);

    generate
        if (LOAD_ASYNC) begin : g_lvl_chk
            // R6: level-sensitive load shows the parallel inputs while held
            a_r6_level_load: assert property (@(posedge clk) disable iff (!primed)
                (load_mode && $stable(par_hi)) |-> tap_out == par_hi);
        end else begin : g_clk_chk
            // R5: clocked load takes the parallel inputs on the edge
            a_r5_clocked_load: assert property (@(posedge clk) disable iff (!primed)
                load_mode |=> tap_out == $past(par_hi));
        end
    endgenerate
endmodule

bind srl_tapped srl_tapped_chk #(
    .STAGES     (STAGES),
    .TAP_FIRST  (TAP_FIRST),
    .LOAD_ASYNC (LOAD_ASYNC)
) u_chk (
    .clk       (clk),
    .ser_in    (ser_in),
    .load_mode (load_mode),
    .par_hi    (par_in[STAGES-1:TAP_FIRST-1]),
    .tap_out   (tap_out)
);

// File: tb/srl_tapped_bench.sv
module srl_tapped_bench;
    localparam int NVEC = 20;
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'h96}, {1'b1, 1'b0, 8'h69}, {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hE1}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic dclk;
    logic ser = 1'b0;
    logic load = 1'b0;
    logic [7:0] par = 8'h00;
    logic [2:0] tap_s, tap_a;
    logic [7:0] m;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign dclk = clk & clk_en;

    srl_tapped #(.LOAD_ASYNC(1'b0)) u_srl_tapped (
        .clk(dclk), .ser_in(ser), .load_mode(load), .par_in(par), .tap_out(tap_s));
    srl_tapped #(.LOAD_ASYNC(1'b1)) u_srl_tapped_async (
        .clk(dclk), .ser_in(ser), .load_mode(load), .par_in(par), .tap_out(tap_a));

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input string req, input logic ld, input logic s, input logic [7:0] p);
        @(negedge clk);
        load = ld; ser = s; par = p;
        @(posedge clk);
        m = ld ? p : {m[6:0], s};
        #2;
        check({req, " clocked"}, tap_s, m[7:5]);
        check({req, " level"}, tap_a, m[7:5]);
    endtask

    initial begin
        // R2: first load sets taps to par_in[7:5]
        step("R2 first load", 1'b1, 1'b0, 8'hA5);
        check("R2 tap value", tap_s, 3'b101);

        // R3 / R8: table walk against the model
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][9] ? "R8 load" : "R3 shift", VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // R1: byte order on the serial end
        step("R1 load", 1'b1, 1'b1, 8'hCA);
        check("R1 k=0", {2'b00, tap_s[2]}, {2'b00, 1'b1});
        for (int k = 1; k < 8; k++) begin
            step("R1 shift", 1'b0, 1'b0, 8'h00);
            check("R1 serial order", {2'b00, tap_s[2]}, {2'b00, 1'(8'hCA >> (7 - k))});
        end

        // R4: latency of a single marked bit
        step("R4 clear", 1'b1, 1'b0, 8'h00);
        step("R4 capture", 1'b0, 1'b1, 8'h00);
        for (int e = 2; e <= 8; e++) begin
            step("R4 shift", 1'b0, 1'b0, 8'h00);
            if (e == 5) check("R4 not yet at tap0", tap_s, 3'b000);
            if (e == 6) check("R4 tap0 at sixth edge", tap_s, 3'b001);
            if (e == 7) check("R4 tap1 at seventh edge", tap_a, 3'b010);
            if (e == 8) check("R4 tap2 at eighth edge", tap_s, 3'b100);
        end

        // R5 / R6: raise control between edges
        step("R5 preset", 1'b1, 1'b0, 8'hE0);
        step("R5 shift", 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        load = 1'b1; par = 8'h40; ser = 1'b1;
        #2;
        check("R5 no load before edge", tap_s, m[7:5]);
        check("R6 immediate load", tap_a, 3'b010);
        @(posedge clk);
        m = 8'h40;
        #2;
        check("R5 load on edge", tap_s, 3'b010);
        check("R6 held across edge", tap_a, 3'b010);
        @(negedge clk);
        load = 1'b0; ser = 1'b1;
        #2;
        check("R6 no shift after drop", tap_a, 3'b010);
        @(posedge clk);
        m = {m[6:0], 1'b1};
        #2;
        check("R6 first shift on edge", tap_a, m[7:5]);
        check("R3 shift clocked", tap_s, m[7:5]);

        // R7: stopped clock, serial input toggling
        @(negedge clk);
        clk_en = 1'b0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            ser = ~ser;
        end
        check("R7 hold clocked", tap_s, m[7:5]);
        check("R7 hold level", tap_a, m[7:5]);
        @(negedge clk);
        clk_en = 1'b1;
        step("R7 resume", 1'b0, 1'b1, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule